// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank Controller

This block is a memory-mapped controller for one bank of general-purpose pins (32 by default). Software picks each pin's direction. It changes the driven levels only through write-one set and clear ports, so separate pins can be updated without a read-modify-write. Software reads the pin levels through a multi-stage synchronizer. The controller detects rising and falling edges on the synchronized levels, and each pin has its own enable for each edge.

Detected edges set bits in a status word, and software clears those bits by writing ones to them. The bank is split into groups of 16 pins. Each group drives its own interrupt line, which is the OR of that group's status bits gated by a per-group enable bit. A host reaches every register over a simple 32-bit bus. Writes take effect on the clock edge. Read data is combinational from the address.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every pin is an input (word 0x10 reads all ones) and `pin_oe` is zero. The output data, all edge enables, all status bits and the group enable word at 0x08 read zero, and every `irq` line is low.
- R2: Word 0x10 holds the direction. A bit of 1 makes that pin an input, with its `pin_oe` bit low. A bit of 0 makes it an output, with its `pin_oe` bit high.
- R3: Writing a mask to 0x18 sets those bits of the output data, and writing a mask to 0x1C clears them. Zero bits in the mask leave the output data unchanged. A write to 0x14 has no effect. Reads of 0x14, 0x18 and 0x1C all return the output data, and `pin_out` carries it.
- R4: Word 0x20 returns `pin_in` as seen after the synchronizer (two stages by default). This holds whatever the direction setting, and writes to 0x20 are ignored.
- R5: Writing ones to 0x24 enables rising-edge detection for those pins, and writing ones to 0x28 disables it. Writing ones to 0x2C enables falling-edge detection, and writing ones to 0x30 disables it. Reads of 0x24 and 0x28 return the rising enables. Reads of 0x2C and 0x30 return the falling enables.
- R6: A status bit in word 0x34 is set on the clock edge after the synchronized level changes, but only when that edge direction is enabled for the pin. An edge whose direction is not enabled leaves the status bit as it was.
- R7: Writing ones to 0x34 clears those status bits. Zero bits in the written mask leave their status bits unchanged.
- R8: If an enabled edge is detected on the same clock edge that software clears that status bit, the bit stays set.
- R9: `irq[g]` is high exactly when bit g of word 0x08 is set and at least one of status bits 16g to 16g+15 is set. Word 0x08 keeps only one bit per group, and the other written bits are dropped.
- R10: An address outside 0x08 and 0x10 to 0x34, or one that is not word-aligned, reads zero and ignores writes. Whenever `bus_sel` is low, `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | 32 | Pad levels, asynchronous |
| pin_out | output | 32 | Driven output levels |
| pin_oe | output | 32 | Output enable per pin, high means drive |
| irq | output | 2 | Interrupt line per 16-pin group |

## Verification
The assertions assume that reset is applied before the first edge and that, once reset is released, the bus inputs hold defined values on every clock edge. They also assume that `pin_in` is never X, because the edge logic compares successive synchronized samples. The stimulus changes every input only at the falling clock edge and always to a defined value, so every input is stable at each rising edge. That covers both the directed sequences and the random phase.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   // Byte offsets of the group-enable word and of the start of the bank window
   localparam int unsigned GRP_EN_OFS = 'h08;
   localparam int unsigned BANK_OFS   = 'h10;
   localparam int unsigned BANK_WORDS = 10;

   // Word index inside the bank window; the order is fixed by the address map
   typedef enum logic [3:0] {
      W_DIR  = 4'd0,
      W_OUT  = 4'd1,
      W_SET  = 4'd2,
      W_CLR  = 4'd3,
      W_IN   = 4'd4,
      W_RSET = 4'd5,
      W_RCLR = 4'd6,
      W_FSET = 4'd7,
      W_FCLR = 4'd8,
      W_STAT = 4'd9
   } bank_word_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q_sync
);
   logic [W-1:0] chain_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= '0;
               else        chain_q[s] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= '0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] rise_en,
   input  logic [W-1:0] fall_en,
   input  logic [W-1:0] clr_mask,
   output logic [W-1:0] status
);
   logic [W-1:0] prev_q;
   logic [W-1:0] evt;
   logic [W-1:0] stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   assign evt = (lvl & ~prev_q & rise_en) | (~lvl & prev_q & fall_en);

   // A fresh edge overrides a simultaneous write-one clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~clr_mask) | evt;
   end

   assign status = stat_q;

   AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt & clr_mask)) |=> ((stat_q & $past(evt & clr_mask)) == $past(evt & clr_mask))); // R8
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_mask & ~evt)) |=> ((stat_q & $past(clr_mask & ~evt)) == '0)); // R7
   AST_STATUS_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(rise_en | fall_en)) == '0)); // R6
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
   parameter int W       = 32,
   parameter int GROUP_W = 16,
   localparam int NGROUP = W / GROUP_W
) (
   input  logic [W-1:0]      status,
   input  logic [NGROUP-1:0] grp_en,
   output logic [NGROUP-1:0] irq
);
   generate
      for (genvar g = 0; g < NGROUP; g++) begin : g_grp
         assign irq[g] = grp_en[g] & (|status[g*GROUP_W +: GROUP_W]);
      end
   endgenerate
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int GROUP_W     = 16,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 8,
   localparam int NGROUP     = NPINS / GROUP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic [NGROUP-1:0] irq
);
   localparam int BANK_END = BANK_OFS + 4 * BANK_WORDS;

   generate
      if (NPINS > 32 || NPINS < 1)         begin : g_chk_pins  $error("NPINS must be 1..32");            end
      if (NPINS % GROUP_W != 0)            begin : g_chk_grp   $error("NPINS must be a multiple of GROUP_W"); end
      if (SYNC_STAGES < 2)                 begin : g_chk_sync  $error("SYNC_STAGES must be at least 2");  end
      if (ADDR_W < 6 || ADDR_W > 16)       begin : g_chk_addr  $error("ADDR_W must be 6..16");            end
   endgenerate

   // Address decode
   logic [ADDR_W-1:0] rel_addr;
   logic              hit_bank, hit_grp, wr_en;
   bank_word_e        word_sel;
   logic              unused_wbits;

   assign rel_addr     = bus_addr - ADDR_W'(BANK_OFS);
   assign hit_bank     = (32'(bus_addr) >= BANK_OFS) && (32'(bus_addr) < BANK_END) && (bus_addr[1:0] == 2'b00);
   assign hit_grp      = (32'(bus_addr) == GRP_EN_OFS);
   assign word_sel     = bank_word_e'(rel_addr[5:2]);
   assign wr_en        = bus_sel & bus_wr;
   assign unused_wbits = ^bus_wdata;

   logic [NPINS-1:0]  wmask;
   assign wmask = bus_wdata[NPINS-1:0];

   // Control state
   logic [NPINS-1:0]  dir_q, out_q, ren_q, fen_q;
   logic [NGROUP-1:0] gen_q;
   logic [NPINS-1:0]  lvl_sync, stat, clr_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '1;
         out_q <= '0;
         ren_q <= '0;
         fen_q <= '0;
         gen_q <= '0;
      end else if (wr_en) begin
         if (hit_grp) gen_q <= bus_wdata[NGROUP-1:0];
         if (hit_bank) begin
            unique case (word_sel)
               W_DIR:   dir_q <= wmask;
               W_SET:   out_q <= out_q | wmask;
               W_CLR:   out_q <= out_q & ~wmask;
               W_RSET:  ren_q <= ren_q | wmask;
               W_RCLR:  ren_q <= ren_q & ~wmask;
               W_FSET:  fen_q <= fen_q | wmask;
               W_FCLR:  fen_q <= fen_q & ~wmask;
               default: ;
            endcase
         end
      end
   end

   assign clr_mask = (wr_en && hit_bank && word_sel == W_STAT) ? wmask : '0;

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_in),
      .q_sync  (lvl_sync)
   );

   gpio_edge_unit #(.W(NPINS)) edge_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (lvl_sync),
      .rise_en  (ren_q),
      .fall_en  (fen_q),
      .clr_mask (clr_mask),
      .status   (stat)
   );

   gpio_irq_group #(.W(NPINS), .GROUP_W(GROUP_W)) irq_i (
      .status (stat),
      .grp_en (gen_q),
      .irq    (irq)
   );

   // Read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_sel && hit_grp) bus_rdata = 32'(gen_q);
      else if (bus_sel && hit_bank) begin
         unique case (word_sel)
            W_DIR:                bus_rdata = 32'(dir_q);
            W_OUT, W_SET, W_CLR:  bus_rdata = 32'(out_q);
            W_IN:                 bus_rdata = 32'(lvl_sync);
            W_RSET, W_RCLR:       bus_rdata = 32'(ren_q);
            W_FSET, W_FCLR:       bus_rdata = 32'(fen_q);
            W_STAT:               bus_rdata = 32'(stat);
            default:              bus_rdata = '0;
         endcase
      end
   end

   assign pin_out = out_q;
   assign pin_oe  = ~dir_q;

   AST_OUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit_bank && word_sel == W_SET) |=> ((pin_out & $past(wmask)) == $past(wmask))); // R3
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(pin_out)); // R3
   AST_IRQ_FALL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (|(~irq & $past(irq))) |-> $past(wr_en)); // R9
   AST_NO_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |-> (bus_rdata == '0)); // R10
endmodule

// File: tb/gpio_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_tb_top;
   localparam int SYNC = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out, pin_oe;
   logic [1:0]  irq;

   int checks = 0;
   int errors = 0;
   bit live = 1'b0;

   always #2 clk = ~clk;

   gpio_bank_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   // Behavioural reference model
   logic [31:0] m_dir, m_out, m_re, m_fe, m_st, m_in, m_prev;
   logic [1:0]  m_ben;
   logic [31:0] sq[$];

   function automatic logic [31:0] m_read(logic sel, logic [7:0] a);
      if (!sel) return 0;
      case (a)
         8'h08: return {30'd0, m_ben};
         8'h10: return m_dir;
         8'h14, 8'h18, 8'h1C: return m_out;
         8'h20: return m_in;
         8'h24, 8'h28: return m_re;
         8'h2C, 8'h30: return m_fe;
         8'h34: return m_st;
         default: return 0;
      endcase
   endfunction

   function automatic string req_of(logic [7:0] a);
      case (a)
         8'h08: return "R9";
         8'h10: return "R2";
         8'h14, 8'h18, 8'h1C: return "R3";
         8'h20: return "R4";
         8'h24, 8'h28, 8'h2C, 8'h30: return "R5";
         8'h34: return "R6";
         default: return "R10";
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_dir = '1; m_out = 0; m_re = 0; m_fe = 0; m_st = 0;
         m_in = 0; m_prev = 0; m_ben = 0;
         sq.delete();
         for (int i = 0; i < SYNC; i++) sq.push_back(32'd0);
      end else begin
         logic [31:0] ev, w;
         ev = (m_in & ~m_prev & m_re) | (~m_in & m_prev & m_fe);
         w = bus_wdata;
         if (bus_sel && bus_wr) begin
            case (bus_addr)
               8'h08: m_ben = w[1:0];
               8'h10: m_dir = w;
               8'h18: m_out = m_out | w;
               8'h1C: m_out = m_out & ~w;
               8'h24: m_re = m_re | w;
               8'h28: m_re = m_re & ~w;
               8'h2C: m_fe = m_fe | w;
               8'h30: m_fe = m_fe & ~w;
               8'h34: m_st = m_st & ~w;
               default: ;
            endcase
         end
         m_st = m_st | ev;
         sq.push_back(pin_in);
         void'(sq.pop_front());
         m_prev = m_in;
         m_in = sq[0];
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   // Compare against the model on every clock, away from the edge
   always @(posedge clk) begin
      #1;
      if (live && rst_n) begin
         chk("R3", pin_out, m_out);
         chk("R2", pin_oe, ~m_dir);
         chk("R9", {30'd0, irq}, {30'd0, m_ben[1] & |m_st[31:16], m_ben[0] & |m_st[15:0]});
         chk(req_of(bus_addr), bus_rdata, m_read(bus_sel, bus_addr));
      end
   end

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   initial begin
      #(4.0 * 200000);
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      live = 1;
      // R1 reset state
      rd(8'h10, v); chk("R1", v, 32'hFFFF_FFFF);
      rd(8'h14, v); chk("R1", v, 32'h0);
      rd(8'h34, v); chk("R1", v, 32'h0);
      rd(8'h08, v); chk("R1", v, 32'h0);
      rd(8'h24, v); chk("R1", v, 32'h0);
      chk("R1", pin_oe, 32'h0);
      chk("R1", {30'd0, irq}, 32'h0);
      // R2 direction
      wr(8'h10, 32'h0000_FFFF);
      chk("R2", pin_oe, 32'hFFFF_0000);
      // R3 set/clear ports; direct write ignored
      wr(8'h18, 32'hA5A5_A5A5);
      wr(8'h1C, 32'h0000_FF00);
      rd(8'h14, v); chk("R3", v, 32'hA5A5_00A5);
      wr(8'h14, 32'h0);
      rd(8'h18, v); chk("R3", v, 32'hA5A5_00A5);
      chk("R3", pin_out, 32'hA5A5_00A5);
      // R4 synchronized input, independent of direction
      @(negedge clk) pin_in = 32'h1234_5678;
      wr(8'h20, 32'hFFFF_FFFF);
      idle(2);
      rd(8'h20, v); chk("R4", v, 32'h1234_5678);
      // R5 edge enables
      wr(8'h24, 32'h0000_00FF);
      wr(8'h2C, 32'hFF00_0000);
      wr(8'h28, 32'h0000_000F);
      rd(8'h28, v); chk("R5", v, 32'h0000_00F0);
      rd(8'h30, v); chk("R5", v, 32'hFF00_0000);
      // R6 edges: fall on top byte, rise on enabled low bits only
      @(negedge clk) pin_in = 32'h0;
      idle(4);
      rd(8'h34, v); chk("R6", v, 32'h1200_0000);
      @(negedge clk) pin_in = 32'h0000_00FF;
      idle(4);
      rd(8'h34, v); chk("R6", v, 32'h1200_00F0);
      // R9 group gating
      chk("R9", {30'd0, irq}, 32'h0);
      wr(8'h08, 32'hFFFF_FFFF);
      rd(8'h08, v); chk("R9", v, 32'h3);
      chk("R9", {30'd0, irq}, 32'h3);
      // R7 write-one clear
      wr(8'h34, 32'h0000_00F0);
      rd(8'h34, v); chk("R7", v, 32'h1200_0000);
      chk("R9", {30'd0, irq}, 32'h2);
      // R8 collision: bit 4 rises in the cycle it is being cleared
      @(negedge clk) pin_in = 32'h0000_000F;
      idle(4);
      @(negedge clk) pin_in = 32'h0000_00FF;
      idle(4);
      rd(8'h34, v); chk("R6", v & 32'h10, 32'h10);
      @(negedge clk) pin_in = 32'h0000_000F;
      idle(4);
      @(negedge clk) pin_in = 32'h0000_00FF;
      @(negedge clk);
      wr(8'h34, 32'h0000_0010);
      rd(8'h34, v); chk("R8", v & 32'h10, 32'h10);
      wr(8'h34, 32'h0000_0010);
      rd(8'h34, v); chk("R7", v & 32'h10, 32'h0);
      // R10 unmapped and misaligned addresses
      rd(8'h04, v); chk("R10", v, 32'h0);
      rd(8'h38, v); chk("R10", v, 32'h0);
      rd(8'h11, v); chk("R10", v, 32'h0);
      wr(8'h11, 32'h0);
      rd(8'h10, v); chk("R10", v, 32'h0000_FFFF);
      // Random phase, model compared every clock
      for (int n = 0; n < 400; n++) begin
         @(negedge clk);
         if ($urandom_range(0, 3) == 0) pin_in = $urandom;
         bus_sel = $urandom_range(0, 1);
         bus_wr  = $urandom_range(0, 1);
         bus_addr = 8'($urandom_range(1, 14) * 4);
         bus_wdata = $urandom;
      end
      idle(2);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule